// File: doc/BRIEF.md
# Ethernet MAC Control and Halt Unit

This unit is the control and status block of a 10/100 Ethernet MAC. Software reaches it through a small word-addressed register bus. It holds one 32-bit control word and a missed-packet count register. From the control word it drives the loopback, duplex and link-mode selects to the frame datapath. It also sequences a software reset of the datapath, timed against the MII-domain clock enable.

A halt sequencer follows the transmit and receive packet strobes from the datapath and tells each side when it must stop. A graceful halt takes effect only when the packet in flight has finished. An immediate halt stops transmission at once. On the receive side, an immediate halt stops reception at once only if the address phase of the current frame has not yet begun; otherwise the frame is allowed to complete first.

A missed-packet event input increments the count register. When the count crosses from 0x7FFF to 0x8000, a rollover flag is raised and, if enabled, an interrupt. Both are cleared when software reads the count register.

Top module: `emac_ctrl_halt`

## Requirements
- R1: After `rst_n` is released, the control word at address 0 reads 0, the count at address 1 reads 0, and `dp_reset`, `reset_busy`, `irq`, `loop_en`, `dp_full_duplex`, `tx_halted` and `rx_halted` are all low.
- R2: The control word at address 0 has the following fields:
  - bit 0: graceful halt
  - bit 1: immediate halt
  - bit 3: full duplex
  - bit 4: loopback
  - bits 6:5: link mode (00 automatic, 10 MII-clock rate, 01 and 11 reserved but stored)
  - bit 10: read-only rollover flag
  - bit 13: rollover interrupt enable

  Bit 2 and every other bit read 0. Bits 0 and 1 stay set until software writes them to 0.
- R3: Writing 1 to bit 2 raises `reset_busy` on the next cycle and leaves every other control field as written. `dp_reset` rises after the 4th following `mii_tick` pulse and stays high for 4 `mii_tick` pulses. After that, `dp_reset` and `reset_busy` both fall.
- R4: Each `miss_evt` cycle increments the count register. The count wraps from 0xFFFF to 0, or saturates there when `CNT_SAT` is set. The step from 0x7FFF to 0x8000 sets the rollover flag (bit 10), and a read of address 1 clears it. No other step sets the flag.
- R5: `irq` is high exactly while the rollover flag is set and the enable bit 13 is 1.
- R6: `loop_en` follows bit 4, and `link_mode` follows bits 6:5. `dp_full_duplex` follows bit 3 but is forced low while loopback is on.
- R7: With graceful halt set, `tx_halted` and `rx_halted` each rise only once that side's packet in flight has ended. A packet start seen while a side is halted is ignored.
- R8: With immediate halt set, `tx_halted` is high at once. `rx_halted` is also high at once when no receive address phase has been seen in the current frame, and that frame is dropped.
- R9: If immediate halt is set after the receive address phase of the current frame, `rx_halted` stays low until that frame ends and is high from then on.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe (read side effects) |
| bus_addr | input | ADDR_W | Word address: 0 control, 1 count |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for the addressed register |
| mii_tick | input | 1 | One pulse per MII tx/rx clock cycle |
| tx_pkt_start | input | 1 | Transmit packet begins |
| tx_pkt_end | input | 1 | Transmit packet ends |
| rx_pkt_start | input | 1 | Receive packet begins |
| rx_addr_phase | input | 1 | Receive destination-address processing begins |
| rx_pkt_end | input | 1 | Receive packet ends |
| miss_evt | input | 1 | One missed packet |
| dp_reset | output | 1 | Reset to datapath state machines and FIFOs |
| reset_busy | output | 1 | Software reset sequence in progress |
| loop_en | output | 1 | Internal loopback select |
| dp_full_duplex | output | 1 | Effective duplex select |
| link_mode | output | 2 | Link mode select |
| irq | output | 1 | Rollover interrupt |
| tx_halted | output | 1 | Transmit halt in effect |
| rx_halted | output | 1 | Receive halt in effect |

## Verification
The assertions cover every cycle. They check that `dp_reset` is never high outside the busy window and that the interrupt never appears without the flag. They check that a count read with no coincident event clears the flag, and that loopback always masks duplex. They also check that an immediate halt raises the transmit halt and, before the address phase, the receive halt, and that a packet in flight under graceful halt is never reported halted. The exact count of MII pulses before and during the datapath reset, the rollover boundary and the wrap of the counter, and the preservation of the other fields across a reset can only be shown by the bench's directed sequences. The same holds for ignored packet starts and for completing a frame whose address phase has begun.

// File: rtl/emac_ctrl_halt.sv
module emac_ctrl_halt #(
  parameter int CNT_W     = 16,
  parameter bit CNT_SAT   = 1'b0,
  parameter int RST_DELAY = 4,
  parameter int RST_HOLD  = 4,
  parameter int ADDR_W    = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  input  logic              mii_tick,
  input  logic              tx_pkt_start,
  input  logic              tx_pkt_end,
  input  logic              rx_pkt_start,
  input  logic              rx_addr_phase,
  input  logic              rx_pkt_end,
  input  logic              miss_evt,
  output logic              dp_reset,
  output logic              reset_busy,
  output logic              loop_en,
  output logic              dp_full_duplex,
  output logic [1:0]        link_mode,
  output logic              irq,
  output logic              tx_halted,
  output logic              rx_halted
);

  localparam int TMAX = (RST_DELAY > RST_HOLD) ? RST_DELAY : RST_HOLD;
  localparam int TW   = $clog2(TMAX + 1);
  localparam logic [ADDR_W-1:0] A_CTRL = '0;
  localparam logic [ADDR_W-1:0] A_CNT  = ADDR_W'(1);
  localparam logic [CNT_W-1:0]  C_HALF = {1'b1, {(CNT_W-1){1'b0}}};
  localparam logic [CNT_W-1:0]  C_PRE  = C_HALF - CNT_W'(1);
  localparam logic [CNT_W-1:0]  C_TOP  = '1;
  localparam logic [TW-1:0]     T_DLY  = TW'(RST_DELAY - 1);
  localparam logic [TW-1:0]     T_HLD  = TW'(RST_HOLD - 1);

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_HOLD} rst_st_t;

  logic             hreq_q, himm_q, fdup_q, loop_q, ren_q, roll_q;
  logic [1:0]       mode_q;
  logic [CNT_W-1:0] cnt_q;
  rst_st_t          st_q;
  logic [TW-1:0]    tcnt_q;
  logic             tx_act_q, rx_act_q, rx_addr_q;

  wire ctrl_wr = bus_wr && (bus_addr == A_CTRL);
  wire cnt_rd  = bus_rd && (bus_addr == A_CNT);

  // Control fields
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      hreq_q <= 1'b0;
      himm_q <= 1'b0;
      fdup_q <= 1'b0;
      loop_q <= 1'b0;
      mode_q <= 2'b00;
      ren_q  <= 1'b0;
    end else if (ctrl_wr) begin
      hreq_q <= bus_wdata[0];
      himm_q <= bus_wdata[1];
      fdup_q <= bus_wdata[3];
      loop_q <= bus_wdata[4];
      mode_q <= bus_wdata[6:5];
      ren_q  <= bus_wdata[13];
    end
  end

  // Software reset sequencer, counted in MII ticks
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= S_IDLE;
      tcnt_q <= '0;
    end else begin
      unique case (st_q)
        S_IDLE: if (ctrl_wr && bus_wdata[2]) begin
          st_q   <= S_WAIT;
          tcnt_q <= '0;
        end
        S_WAIT: if (mii_tick) begin
          if (tcnt_q == T_DLY) begin
            st_q   <= S_HOLD;
            tcnt_q <= '0;
          end else tcnt_q <= tcnt_q + TW'(1);
        end
        S_HOLD: if (mii_tick) begin
          if (tcnt_q == T_HLD) begin
            st_q   <= S_IDLE;
            tcnt_q <= '0;
          end else tcnt_q <= tcnt_q + TW'(1);
        end
        default: st_q <= S_IDLE;
      endcase
    end
  end

  assign reset_busy = (st_q != S_IDLE);
  assign dp_reset   = (st_q == S_HOLD);

  // Missed-packet counter and rollover flag
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q  <= '0;
      roll_q <= 1'b0;
    end else begin
      if (miss_evt && !(CNT_SAT && cnt_q == C_TOP))
        cnt_q <= cnt_q + CNT_W'(1);
      if (miss_evt && cnt_q == C_PRE) roll_q <= 1'b1;
      else if (cnt_rd)                roll_q <= 1'b0;
    end
  end

  assign irq = roll_q & ren_q;

  // Halt sequencer
  assign tx_halted = himm_q | (hreq_q & ~tx_act_q);
  assign rx_halted = (himm_q & ~rx_addr_q) | ((hreq_q | himm_q) & ~rx_act_q);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_act_q  <= 1'b0;
      rx_act_q  <= 1'b0;
      rx_addr_q <= 1'b0;
    end else if (dp_reset) begin
      tx_act_q  <= 1'b0;
      rx_act_q  <= 1'b0;
      rx_addr_q <= 1'b0;
    end else begin
      if (himm_q || tx_pkt_end)           tx_act_q <= 1'b0;
      else if (tx_pkt_start && !tx_halted) tx_act_q <= 1'b1;

      if ((himm_q && !rx_addr_q) || rx_pkt_end) rx_act_q <= 1'b0;
      else if (rx_pkt_start && !rx_halted)        rx_act_q <= 1'b1;

      if (rx_pkt_end || !rx_act_q)  rx_addr_q <= 1'b0;
      else if (rx_addr_phase)       rx_addr_q <= 1'b1;
    end
  end

  // Datapath selects
  assign loop_en        = loop_q;
  assign dp_full_duplex = fdup_q & ~loop_q;
  assign link_mode      = mode_q;

  // Read mux
  wire [31:0] ctrl_word = {18'b0, ren_q, 2'b0, roll_q, 3'b0, mode_q,
                           loop_q, fdup_q, 1'b0, himm_q, hreq_q};

  always_comb begin
    if (bus_addr == A_CTRL)     bus_rdata = ctrl_word;
    else if (bus_addr == A_CNT) bus_rdata = 32'(cnt_q);
    else                        bus_rdata = '0;
  end

endmodule

// File: rtl/emac_ctrl_halt_chk.sv
module emac_ctrl_halt_chk #(
  parameter int ADDR_W = 2
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_rd,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              miss_evt,
  input logic              dp_reset,
  input logic              reset_busy,
  input logic              loop_en,
  input logic              dp_full_duplex,
  input logic              irq,
  input logic              tx_halted,
  input logic              rx_halted,
  input logic              roll_q,
  input logic              himm_q,
  input logic              hreq_q,
  input logic              tx_act_q,
  input logic              rx_act_q,
  input logic              rx_addr_q
);

  p_dpreset_in_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    dp_reset |-> reset_busy);

  p_busy_falls_after_dpreset_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(reset_busy) |-> $past(dp_reset));

  p_roll_clear_on_read_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == ADDR_W'(1) && !miss_evt) |=> !roll_q);

  p_irq_needs_flag_r5: assert property (@(posedge clk) disable iff (!rst_n)
    irq |-> roll_q);

  p_loop_masks_duplex_r6: assert property (@(posedge clk) disable iff (!rst_n)
    loop_en |-> !dp_full_duplex);

  p_graceful_waits_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (hreq_q && !himm_q && tx_act_q) |-> !tx_halted);

  p_imm_tx_r8: assert property (@(posedge clk) disable iff (!rst_n)
    himm_q |-> tx_halted);

  p_imm_rx_early_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (himm_q && !rx_addr_q) |-> rx_halted);

  p_imm_rx_late_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_act_q && rx_addr_q && !hreq_q) |-> !rx_halted);

endmodule

bind emac_ctrl_halt emac_ctrl_halt_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_rd(bus_rd), .bus_addr(bus_addr),
  .miss_evt(miss_evt), .dp_reset(dp_reset), .reset_busy(reset_busy),
  .loop_en(loop_en), .dp_full_duplex(dp_full_duplex), .irq(irq),
  .tx_halted(tx_halted), .rx_halted(rx_halted), .roll_q(roll_q),
  .himm_q(himm_q), .hreq_q(hreq_q), .tx_act_q(tx_act_q),
  .rx_act_q(rx_act_q), .rx_addr_q(rx_addr_q)
);

// File: tb/sim_emac_ctrl_halt.sv
`timescale 1ns/1ps
module sim_emac_ctrl_halt;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        bus_wr = 1'b0, bus_rd = 1'b0;
  logic [1:0]  bus_addr = '0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic        mii_tick = 1'b0;
  logic        tx_pkt_start = 1'b0, tx_pkt_end = 1'b0;
  logic        rx_pkt_start = 1'b0, rx_addr_phase = 1'b0, rx_pkt_end = 1'b0;
  logic        miss_evt = 1'b0;
  logic        dp_reset, reset_busy, loop_en, dp_full_duplex, irq;
  logic        tx_halted, rx_halted;
  logic [1:0]  link_mode;

  int nvec = 0;
  int nbad = 0;

  always #10 clk = ~clk;

  emac_ctrl_halt u0 (
    .clk(clk), .rst_n(rst_n), .bus_wr(bus_wr), .bus_rd(bus_rd),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
    .mii_tick(mii_tick), .tx_pkt_start(tx_pkt_start), .tx_pkt_end(tx_pkt_end),
    .rx_pkt_start(rx_pkt_start), .rx_addr_phase(rx_addr_phase),
    .rx_pkt_end(rx_pkt_end), .miss_evt(miss_evt), .dp_reset(dp_reset),
    .reset_busy(reset_busy), .loop_en(loop_en), .dp_full_duplex(dp_full_duplex),
    .link_mode(link_mode), .irq(irq), .tx_halted(tx_halted), .rx_halted(rx_halted)
  );

  // wdata, expected readback, loop, duplex, mode
  localparam logic [67:0] VEC [5] = '{
    {32'h0000_0018, 32'h0000_0018, 1'b1, 1'b0, 2'd0},
    {32'h0000_0008, 32'h0000_0008, 1'b0, 1'b1, 2'd0},
    {32'h0000_0040, 32'h0000_0040, 1'b0, 1'b0, 2'd2},
    {32'hFFFF_FFFB, 32'h0000_207B, 1'b1, 1'b0, 2'd3},
    {32'h0000_2060, 32'h0000_2060, 1'b0, 1'b0, 2'd3}
  };

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    nvec++;
    if (act !== exp) begin
      nbad++;
      $display("FAIL %s: got %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [31:0] d);
    @(negedge clk);
    bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_rd = 1'b1; bus_addr = a;
    #1 d = bus_rdata;
    @(negedge clk);
    bus_rd = 1'b0;
  endtask

  task automatic peek(input logic [1:0] a, output logic [31:0] d);
    @(negedge clk);
    bus_addr = a;
    #1 d = bus_rdata;
  endtask

  task automatic ticks(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); mii_tick = 1'b1;
      @(negedge clk); mii_tick = 1'b0;
    end
  endtask

  task automatic pulse(ref logic s);
    @(negedge clk); s = 1'b1;
    @(negedge clk); s = 1'b0;
  endtask

  task automatic misses(input int n);
    @(negedge clk); miss_evt = 1'b1;
    repeat (n) @(negedge clk);
    miss_evt = 1'b0;
  endtask

  task automatic wrap_up;
    $display("== %0d vectors applied, %0d miscompares ==", nvec, nbad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    nvec++; nbad++;
    $display("FAIL watchdog: got timeout expected completion");
    wrap_up();
  end

  initial begin
    logic [31:0] d;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R1 reset state
    peek(2'd0, d); chk("R1 ctrl", d, 32'h0);
    peek(2'd1, d); chk("R1 count", d, 32'h0);
    chk("R1 outputs", {25'b0, dp_reset, reset_busy, irq, loop_en, dp_full_duplex,
        tx_halted, rx_halted}, 32'h0);

    // R2/R6 vector walk over the control word
    for (int i = 0; i < 5; i++) begin
      wr(2'd0, VEC[i][67:36]);
      peek(2'd0, d);
      chk("R2 readback", d, VEC[i][35:4]);
      chk("R6 loop", 32'(loop_en), 32'(VEC[i][3]));
      chk("R6 duplex", 32'(dp_full_duplex), 32'(VEC[i][2]));
      chk("R6 mode", 32'(link_mode), 32'(VEC[i][1:0]));
    end

    // R3 software reset timing and field preservation
    wr(2'd0, 32'h0000_001C);
    #1 chk("R3 busy", 32'(reset_busy), 32'd1);
    chk("R3 no early reset", 32'(dp_reset), 32'd0);
    peek(2'd0, d); chk("R3 fields kept", d, 32'h0000_0018);
    ticks(3);
    #1 chk("R3 after 3 ticks", 32'(dp_reset), 32'd0);
    ticks(1);
    #1 chk("R3 after 4 ticks", 32'(dp_reset), 32'd1);
    ticks(3);
    #1 chk("R3 held", {30'b0, dp_reset, reset_busy}, 32'd3);
    ticks(1);
    #1 chk("R3 done", {30'b0, dp_reset, reset_busy}, 32'd0);
    peek(2'd0, d); chk("R3 fields after", d, 32'h0000_0018);
    wr(2'd0, 32'h0);

    // R4/R5 counter rollover
    misses(32767);
    peek(2'd1, d); chk("R4 count 7fff", d, 32'h0000_7FFF);
    peek(2'd0, d); chk("R4 no flag yet", d, 32'h0);
    misses(1);
    peek(2'd0, d); chk("R4 flag set", d, 32'h0000_0400);
    chk("R5 irq masked", 32'(irq), 32'd0);
    wr(2'd0, 32'h0000_2000);
    #1 chk("R5 irq on", 32'(irq), 32'd1);
    rd(2'd1, d); chk("R4 count 8000", d, 32'h0000_8000);
    #1 chk("R5 irq cleared", 32'(irq), 32'd0);
    peek(2'd0, d); chk("R4 flag cleared", d, 32'h0000_2000);
    misses(32768);
    peek(2'd1, d); chk("R4 wrap", d, 32'h0);
    peek(2'd0, d); chk("R4 no flag on wrap", d, 32'h0000_2000);
    wr(2'd0, 32'h0);

    // R7 graceful halt
    pulse(tx_pkt_start);
    pulse(rx_pkt_start);
    wr(2'd0, 32'h0000_0001);
    #1 chk("R7 tx waits", 32'(tx_halted), 32'd0);
    chk("R7 rx waits", 32'(rx_halted), 32'd0);
    pulse(tx_pkt_end);
    #1 chk("R7 tx halted", 32'(tx_halted), 32'd1);
    pulse(rx_pkt_end);
    #1 chk("R7 rx halted", 32'(rx_halted), 32'd1);
    pulse(tx_pkt_start);
    wr(2'd0, 32'h0);
    wr(2'd0, 32'h0000_0001);
    #1 chk("R7 start ignored", 32'(tx_halted), 32'd1);
    wr(2'd0, 32'h0);

    // R8 immediate halt before address phase
    pulse(tx_pkt_start);
    pulse(rx_pkt_start);
    wr(2'd0, 32'h0000_0002);
    #1 chk("R8 tx immediate", 32'(tx_halted), 32'd1);
    chk("R8 rx immediate", 32'(rx_halted), 32'd1);
    wr(2'd0, 32'h0);
    #1 chk("R8 frame dropped", 32'(rx_halted), 32'd0);
    wr(2'd0, 32'h0000_0001);
    #1 chk("R8 rx idle after drop", 32'(rx_halted), 32'd1);
    wr(2'd0, 32'h0);

    // R9 immediate halt after address phase
    pulse(rx_pkt_start);
    pulse(rx_addr_phase);
    wr(2'd0, 32'h0000_0002);
    #1 chk("R9 rx completes", 32'(rx_halted), 32'd0);
    pulse(rx_pkt_end);
    #1 chk("R9 rx halted at end", 32'(rx_halted), 32'd1);
    wr(2'd0, 32'h0);

    wrap_up();
  end

endmodule